// File: doc/BRIEF.md
# Prefetch Request Queue with Demand Priority

This block sits between a data-cache prefetch predictor and the memory port that serves cache refills. Predicted addresses are queued in arrival order and sent to memory one at a time, whenever no demand miss is waiting. A demand miss always wins the port over queued prefetches. The port carries one request at a time. A new request can start only after the previous request has completed.

Prefetches that would raise a translation fault are discarded on entry. Two other cases are also dropped: an address that is already waiting in the queue, and any prefetch that arrives while the queue is full. A flush input empties the waiting entries in one cycle and leaves the request that is in progress untouched. The cache can present an address on a lookup port. Two answers come back: whether that address is the request now in progress, which counts as a hit, and whether it is only waiting in the queue, which still counts as a miss. Each completion returns a one-bit kind tag: 0 for a demand request, 1 for a prefetch.

Top module: `pfq_top`

## Requirements
- R1: After reset no memory request is active, `dm_grant` is 0 and no address is reported as queued.
- R2: Queued prefetch addresses reach `mem_req_addr` strictly in their enqueue order. A queued prefetch is issued in the cycle after an idle cycle with no demand and no flush, and this holds only while the queue is non-empty.
- R3: When the port is idle and `dm_valid` is 1, `dm_grant` is 1 in that same cycle. From the next cycle the request is the demand address with `mem_req_is_pf` = 0. This holds even if prefetches are queued.
- R4: A prefetch presented with `pf_fault` = 1 is never queued and never issued.
- R5: While `mem_req_valid` is 1, the address and kind stay stable until `mem_done`. The request drops in the cycle after `mem_done`, and no second request overlaps it.
- R6: `lk_inflight` is 1 exactly when a request is active and its address equals `lk_addr`.
- R7: `lk_queued` is 1 exactly when `lk_addr` matches an entry that is queued but not yet issued. Such an entry never sets `lk_inflight`.
- R8: The queue holds DEPTH (default 30) entries. A prefetch arriving while it is full is dropped.
- R9: A prefetch whose address equals an entry already queued is not queued again.
- R10: `flush` empties every queued entry in one cycle. It leaves the active request intact, and a prefetch offered in the same cycle is dropped.
- R11: `cpl_valid` is 1 when `mem_done` arrives during an active request, and `cpl_is_pf` then gives that request's kind: 1 for a prefetch, 0 for a demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch enqueue request |
| pf_addr | input | AW | Prefetch address |
| pf_fault | input | 1 | Translation of pf_addr would fault |
| dm_valid | input | 1 | Demand miss waiting, held until granted |
| dm_addr | input | AW | Demand miss address |
| dm_grant | output | 1 | Demand taken onto the memory port this cycle |
| flush | input | 1 | Discard all queued prefetches |
| mem_req_valid | output | 1 | A memory request is in progress |
| mem_req_addr | output | AW | Address of the active request |
| mem_req_is_pf | output | 1 | Kind of the active request (1 = prefetch) |
| mem_done | input | 1 | Memory completes the active request |
| cpl_valid | output | 1 | Completion of an active request |
| cpl_is_pf | output | 1 | Kind tag of the completed request |
| lk_addr | input | AW | Cache lookup address |
| lk_inflight | output | 1 | lk_addr is the active request (hit) |
| lk_queued | output | 1 | lk_addr is queued but not issued (miss) |

## Verification
The main stimulus is a long random mix over a small pool of addresses, so that duplicates and lookup matches happen often. This mix combines prefetch offers, faulting offers, demand misses, completions and occasional flushes. Against a reference queue model it separates a wrong issue order, a missing demand priority and a wrong lookup classification. Directed cases then cover the rest. Holding the port busy while offering DEPTH+1 addresses separates the full-queue drop from normal queuing. A repeated address tests duplicate suppression. A faulting offer tests fault filtering. A flush during an active request shows that queued entries vanish while the request in progress survives.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic {
        KIND_DEMAND   = 1'b0,
        KIND_PREFETCH = 1'b1
    } req_kind_e;

    function automatic int unsigned ptr_w(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int unsigned DEPTH = 30,
    parameter int unsigned AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    input  logic          flush,
    input  logic [AW-1:0] lk_addr,
    output logic [AW-1:0] head_addr,
    output logic          empty,
    output logic          lk_match
);
    localparam int unsigned PW = pfq_pkg::ptr_w(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            count;
    } store_t;

    store_t st_q, st_d;

    logic [DEPTH-1:0] dup_vec;
    logic [DEPTH-1:0] lk_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign dup_vec[g] = st_q.vld[g] && (st_q.addr[g] == push_addr);
        assign lk_vec[g]  = st_q.vld[g] && (st_q.addr[g] == lk_addr);
    end

    logic full;
    logic push_ok;

    assign full      = (st_q.count == CW'(DEPTH));
    assign empty     = (st_q.count == '0);
    assign head_addr = st_q.addr[st_q.head];
    assign lk_match  = |lk_vec;
    assign push_ok   = push_req && !flush && !full && !(|dup_vec);

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld   = '0;
            st_d.head  = '0;
            st_d.tail  = '0;
            st_d.count = '0;
        end else begin
            if (pop) begin
                st_d.vld[st_q.head] = 1'b0;
                st_d.head           = nxt(st_q.head);
            end
            if (push_ok) begin
                st_d.vld[st_q.tail]  = 1'b1;
                st_d.addr[st_q.tail] = push_addr;
                st_d.tail            = nxt(st_q.tail);
            end
            st_d.count = st_q.count + CW'(push_ok) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.count != '0));

    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0) && (st_q.vld == '0));

    p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);
endmodule

// File: rtl/pfq_issue.sv
module pfq_issue #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dm_valid,
    input  logic [AW-1:0] dm_addr,
    input  logic          q_empty,
    input  logic [AW-1:0] q_head,
    input  logic          flush,
    input  logic          mem_done,
    input  logic [AW-1:0] lk_addr,
    output logic          pop,
    output logic          dm_grant,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          req_is_pf,
    output logic          cpl_valid,
    output logic          cpl_is_pf,
    output logic          lk_hit
);
    import pfq_pkg::*;

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] addr;
        req_kind_e     kind;
    } port_t;

    port_t pt_q, pt_d;

    always_comb begin
        pt_d     = pt_q;
        dm_grant = 1'b0;
        pop      = 1'b0;
        if (pt_q.busy) begin
            if (mem_done) begin
                pt_d.busy = 1'b0;
            end
        end else if (dm_valid) begin
            dm_grant  = 1'b1;
            pt_d.busy = 1'b1;
            pt_d.addr = dm_addr;
            pt_d.kind = KIND_DEMAND;
        end else if (!q_empty && !flush) begin
            pop       = 1'b1;
            pt_d.busy = 1'b1;
            pt_d.addr = q_head;
            pt_d.kind = KIND_PREFETCH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '{busy: 1'b0, addr: '0, kind: KIND_DEMAND};
        end else begin
            pt_q <= pt_d;
        end
    end

    assign req_valid = pt_q.busy;
    assign req_addr  = pt_q.addr;
    assign req_is_pf = (pt_q.kind == KIND_PREFETCH);
    assign cpl_valid = pt_q.busy && mem_done;
    assign cpl_is_pf = req_is_pf;
    assign lk_hit    = pt_q.busy && (pt_q.addr == lk_addr);

    p_hold_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_done) |=> req_valid && $stable(req_addr) && $stable(req_is_pf));

    p_release_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !req_valid);

    p_demand_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dm_grant |=> req_valid && !req_is_pf && (req_addr == $past(dm_addr)));

    p_pop_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop, dm_grant}));
endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
    parameter int unsigned DEPTH = 30,
    parameter int unsigned AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_valid,
    input  logic [AW-1:0] pf_addr,
    input  logic          pf_fault,
    input  logic          dm_valid,
    input  logic [AW-1:0] dm_addr,
    output logic          dm_grant,
    input  logic          flush,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    output logic          mem_req_is_pf,
    input  logic          mem_done,
    output logic          cpl_valid,
    output logic          cpl_is_pf,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_inflight,
    output logic          lk_queued
);
    logic          q_pop;
    logic          q_empty;
    logic [AW-1:0] q_head;
    logic          pf_ok;

    assign pf_ok = pf_valid && !pf_fault;

    pfq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (pf_ok),
        .push_addr (pf_addr),
        .pop       (q_pop),
        .flush     (flush),
        .lk_addr   (lk_addr),
        .head_addr (q_head),
        .empty     (q_empty),
        .lk_match  (lk_queued)
    );

    pfq_issue #(.AW(AW)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .dm_valid  (dm_valid),
        .dm_addr   (dm_addr),
        .q_empty   (q_empty),
        .q_head    (q_head),
        .flush     (flush),
        .mem_done  (mem_done),
        .lk_addr   (lk_addr),
        .pop       (q_pop),
        .dm_grant  (dm_grant),
        .req_valid (mem_req_valid),
        .req_addr  (mem_req_addr),
        .req_is_pf (mem_req_is_pf),
        .cpl_valid (cpl_valid),
        .cpl_is_pf (cpl_is_pf),
        .lk_hit    (lk_inflight)
    );

    p_fault_not_issued_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_fault && !mem_req_valid && !dm_valid && q_empty)
            |=> !mem_req_valid);

    p_cpl_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_is_pf == mem_req_is_pf));
endmodule

// File: tb/pfq_top_tb.sv
module pfq_top_tb;
    localparam int unsigned DEPTH = 30;
    localparam int unsigned AW    = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pf_valid, pf_fault, dm_valid, flush, mem_done;
    logic [AW-1:0] pf_addr, dm_addr, lk_addr;
    logic          dm_grant, mem_req_valid, mem_req_is_pf, cpl_valid, cpl_is_pf;
    logic          lk_inflight, lk_queued;
    logic [AW-1:0] mem_req_addr;

    always #4 clk = ~clk;

    pfq_top #(.DEPTH(DEPTH), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_fault(pf_fault),
        .dm_valid(dm_valid), .dm_addr(dm_addr), .dm_grant(dm_grant),
        .flush(flush),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_is_pf(mem_req_is_pf), .mem_done(mem_done),
        .cpl_valid(cpl_valid), .cpl_is_pf(cpl_is_pf),
        .lk_addr(lk_addr), .lk_inflight(lk_inflight), .lk_queued(lk_queued)
    );

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          finished = 0;

    // reference model
    logic [AW-1:0] mq[$];
    logic          m_busy = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic          m_pf   = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit in_queue(input logic [AW-1:0] a);
        foreach (mq[i]) if (mq[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    // one cycle: inputs already driven after a negedge
    task automatic step();
        bit grant, popq, pushq;
        #1;
        grant = !m_busy && dm_valid;
        popq  = !m_busy && !dm_valid && !flush && (mq.size() > 0);
        pushq = pf_valid && !pf_fault && !flush && (mq.size() < DEPTH) && !in_queue(pf_addr);
        chk("R5", "mem_req_valid", 64'(mem_req_valid), 64'(m_busy));
        if (m_busy) begin
            chk("R2", "mem_req_addr", 64'(mem_req_addr), 64'(m_addr));
            chk("R3", "mem_req_is_pf", 64'(mem_req_is_pf), 64'(m_pf));
        end
        chk("R3", "dm_grant", 64'(dm_grant), 64'(grant));
        chk("R11", "cpl_valid", 64'(cpl_valid), 64'(m_busy && mem_done));
        if (m_busy && mem_done) chk("R11", "cpl_is_pf", 64'(cpl_is_pf), 64'(m_pf));
        chk("R6", "lk_inflight", 64'(lk_inflight), 64'(m_busy && (m_addr == lk_addr)));
        chk("R7", "lk_queued", 64'(lk_queued), 64'(in_queue(lk_addr)));
        @(posedge clk);
        if (m_busy) begin
            if (mem_done) m_busy = 1'b0;
        end else if (grant) begin
            m_busy = 1'b1; m_addr = dm_addr; m_pf = 1'b0;
        end else if (popq) begin
            m_busy = 1'b1; m_addr = mq[0]; m_pf = 1'b1;
        end
        if (flush) mq.delete();
        else begin
            if (popq) void'(mq.pop_front());
            if (pushq) mq.push_back(pf_addr);
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        pf_valid = 0; pf_fault = 0; pf_addr = '0;
        dm_valid = 0; dm_addr = '0; flush = 0; mem_done = 0; lk_addr = '0;
    endtask

    task automatic look(input logic [AW-1:0] a, output logic q, output logic h);
        lk_addr = a; #1; q = lk_queued; h = lk_inflight;
    endtask

    initial begin
        logic q, h;
        int unsigned r;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1", "reset dm_grant", 64'(dm_grant), 64'd0);
        chk("R1", "reset lk_queued", 64'(lk_queued), 64'd0);

        // R4: faulting offer never queued nor issued
        pf_valid = 1; pf_fault = 1; pf_addr = 32'h40; step();
        idle_inputs(); lk_addr = 32'h40; step();
        chk("R4", "fault addr queued", 64'(lk_queued), 64'd0);
        chk("R4", "fault addr issued", 64'(mem_req_valid), 64'd0);

        // R8: hold port busy with a demand, then offer DEPTH+1 addresses
        dm_valid = 1; dm_addr = 32'h900; step();
        dm_valid = 0;
        for (int i = 0; i <= DEPTH; i++) begin
            pf_valid = 1; pf_fault = 0; pf_addr = 32'h100 + i; step();
        end
        pf_valid = 0;
        look(32'h100 + DEPTH, q, h);
        chk("R8", "entry beyond depth dropped", 64'(q), 64'd0);
        look(32'h100 + DEPTH - 1, q, h);
        chk("R8", "last fitting entry queued", 64'(q), 64'd1);
        // R9: duplicate of queued entry offered again while full-1 after one pop
        mem_done = 1; step(); mem_done = 0; step();
        chk("R2", "first prefetch in order", 64'(mem_req_addr), 64'h100);
        pf_valid = 1; pf_addr = 32'h105; step(); pf_valid = 0;
        // R10: flush during active request
        flush = 1; step(); flush = 0;
        look(32'h105, q, h);
        chk("R10", "queued entry flushed", 64'(q), 64'd0);
        chk("R10", "active request kept", 64'(mem_req_valid), 64'd1);
        look(32'h100, q, h);
        chk("R6", "active prefetch is hit", 64'(h), 64'd1);
        mem_done = 1; step(); mem_done = 0; step();

        // R9: duplicate suppression while busy
        dm_valid = 1; dm_addr = 32'h901; step(); dm_valid = 0;
        pf_valid = 1; pf_addr = 32'h77; step(); step();
        pf_addr = 32'h78; step(); pf_valid = 0;
        mem_done = 1; step(); mem_done = 0; step();
        chk("R2", "dup head issued", 64'(mem_req_addr), 64'h77);
        look(32'h77, q, h);
        chk("R9", "single copy of duplicate", 64'(q), 64'd0);
        chk("R7", "in-flight not counted queued", 64'(h), 64'd1);
        // R3: demand beats queued 0x78
        dm_valid = 1; dm_addr = 32'h902; mem_done = 1; step();
        mem_done = 0; step(); dm_valid = 0;
        chk("R3", "demand before queued prefetch", 64'(mem_req_addr), 64'h902);
        mem_done = 1; step(); mem_done = 0; step();
        chk("R2", "queued prefetch after demand", 64'(mem_req_addr), 64'h78);
        mem_done = 1; step(); idle_inputs(); step();

        // random phase
        r = $urandom(32'd4021);
        for (int c = 0; c < 4000; c++) begin
            pf_valid = ($urandom % 10) < 6;
            pf_fault = ($urandom % 10) == 0;
            pf_addr  = $urandom % 48;
            dm_valid = ($urandom % 7) == 0;
            dm_addr  = 32'h200 + ($urandom % 16);
            mem_done = ($urandom % 10) < 3;
            flush    = ($urandom % 50) == 0;
            lk_addr  = ($urandom % 2) ? ($urandom % 48) : (32'h200 + ($urandom % 16));
            step();
        end
        idle_inputs();
        step();

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule